// File: doc/BRIEF.md
# Single-Clock I2S Stereo Transmitter

This block sends a stereo pair of signed samples to an external audio DAC in I2S framing. It does so without a separate audio clock. The system clock that runs the synthesis core is also the DAC master clock. All the other serial timing is divided down from that clock. One stereo frame lasts exactly 256 system clocks: 64 bit clocks of 4 cycles each, split into a 32-bit left slot and a 32-bit right slot. With a system clock of about 12.727 MHz, the sample rate is close to 49.71 kHz.

The two channel inputs are captured together at the frame boundary. The captured pair is then held for the whole frame. Each input is widened to the 24-bit DAC word, either by sign extension or by left justification, as chosen by a parameter. A one-cycle request strobe appears at a fixed position in every frame. It serves as the sample tick of the upstream core, which answers by presenting the next pair before the boundary.

Top module: `i2s_frame_tx`

## Requirements
- R1: `mclk_o` carries the system clock itself: it is high while `clk_i` is high and low while `clk_i` is low.
- R2: Frame position is counted from the first clock edge after reset is released, and the frame repeats every 256 cycles. `bclk_o` is low for the first two cycles of each 4-cycle bit period and high for the last two, which gives 64 bit periods per frame.
- R3: `ws_o` is 0 during frame cycles 0..127 (left slot) and 1 during cycles 128..255 (right slot). It changes only in a cycle where `bclk_o` has just fallen.
- R4: Within each 32-bit slot, slot bit 0 and slot bits 25..31 are 0. Slot bits 1..24 carry the 24-bit word with the MSB first: slot bit n carries word bit 24-n.
- R5: `sd_o` changes only in a cycle where `bclk_o` has just fallen, which is frame cycle 4k.
- R6: Both channel inputs are captured together by the clock edge that ends frame cycle 255, and they are used for the whole following frame. Input values at any other edge have no effect on `sd_o`.
- R7: With sign-extension alignment, a 16-bit sample s becomes the word {8 copies of s[15], s}.
- R8: With left-justify alignment, a 16-bit sample s becomes the word {s, 8'h00}.
- R9: `sample_req_o` is high for exactly one cycle per frame, in frame cycle `REQ_POS` (default 4).
- R10: Synchronous active-high reset clears `bclk_o`, `ws_o`, `sd_o` and `sample_req_o`, and restarts the frame at cycle 0. It also clears the held words, so the first frame after reset sends zeros on both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the DAC master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| left_i | input | SAMPLE_W | Signed left-channel sample |
| right_i | input | SAMPLE_W | Signed right-channel sample |
| sample_req_o | output | 1 | One-cycle request for the next stereo pair |
| mclk_o | output | 1 | DAC master clock (forwarded system clock) |
| bclk_o | output | 1 | Serial bit clock, system clock / 4 |
| ws_o | output | 1 | Word select, 0 = left, 1 = right |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
The bench builds two copies of the block with the default frame geometry and a 16-bit sample width: one with sign-extension alignment and one with left-justify alignment. It compares every output with an arithmetic model in every cycle, over fourteen whole frames. This covers every bit position of both slots, the frame wrap and the request position. Between boundaries the inputs are driven with fresh pseudo-random values each cycle, so any capture at the wrong edge corrupts the data. The capture values at the boundaries include the full-scale and sign-boundary codes, which exercise the sign extension and the zero padding.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // How a sample narrower than the DAC word is widened.
  typedef enum logic {
    ALIGN_SIGN = 1'b0,   // sign-extend into the low bits
    ALIGN_LEFT = 1'b1    // place at the MSB end, zero-fill below
  } align_e;

  // Channel index used for the per-channel capture registers.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/i2s_timebase.sv
module i2s_timebase #(
  parameter int BCLK_DIV  = 4,
  parameter int SLOT_BITS = 32,
  parameter int REQ_POS   = 4,
  parameter int PH_W      = 2,
  parameter int BIT_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [BIT_W-1:0] bit_nxt_o,
  output logic             fall_nxt_o,
  output logic             load_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             req_o
);

  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int HALF_DIV   = BCLK_DIV / 2;
  localparam int REQ_BIT    = REQ_POS / BCLK_DIV;
  localparam int REQ_PH     = REQ_POS % BCLK_DIV;

  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  phase_nxt;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] bit_nxt;
  logic             phase_wrap;
  logic             bit_wrap;
  logic             bclk_q;
  logic             ws_q;
  logic             req_q;

  always_comb begin
    phase_wrap = (phase_q == PH_W'(BCLK_DIV - 1));
    bit_wrap   = (bit_q == BIT_W'(FRAME_BITS - 1));
    phase_nxt  = phase_wrap ? '0 : phase_q + 1'b1;
    if (phase_wrap) begin
      bit_nxt = bit_wrap ? '0 : bit_q + 1'b1;
    end else begin
      bit_nxt = bit_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      bit_q   <= '0;
      bclk_q  <= 1'b0;
      ws_q    <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      bit_q   <= bit_nxt;
      bclk_q  <= (phase_nxt >= PH_W'(HALF_DIV));
      ws_q    <= (bit_nxt >= BIT_W'(SLOT_BITS));
      req_q   <= (bit_nxt == BIT_W'(REQ_BIT)) && (phase_nxt == PH_W'(REQ_PH));
    end
  end

  assign bit_nxt_o  = bit_nxt;
  assign fall_nxt_o = (phase_nxt == '0);
  assign load_o     = phase_wrap && bit_wrap;
  assign bclk_o     = bclk_q;
  assign ws_o       = ws_q;
  assign req_o      = req_q;

  // Bit clock may only toggle at the start or the middle of a bit period.
  assert_bclk_edges_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(bclk_q) |-> (phase_q == '0 || phase_q == PH_W'(HALF_DIV)));

  // Word select moves only together with a falling bit clock.
  assert_ws_on_fall_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(ws_q) |-> $fell(bclk_q));

  // Request strobe is a single-cycle pulse.
  assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    req_q |=> !req_q);

  // Capture enable fires once per frame, never on two cycles in a row.
  assert_load_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |=> !load_o);

endmodule

// File: rtl/i2s_sample_latch.sv
module i2s_sample_latch
  import i2s_tx_pkg::*;
#(
  parameter int     SAMPLE_W  = 16,
  parameter int     WORD_BITS = 24,
  parameter align_e ALIGN     = ALIGN_SIGN
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 load_i,
  input  logic [SAMPLE_W-1:0]  left_i,
  input  logic [SAMPLE_W-1:0]  right_i,
  output logic [WORD_BITS-1:0] word_l_o,
  output logic [WORD_BITS-1:0] word_r_o
);

  localparam int PAD_W = (WORD_BITS > SAMPLE_W) ? (WORD_BITS - SAMPLE_W) : 1;

  logic [SAMPLE_W-1:0]  samp [NUM_CH];
  logic [WORD_BITS-1:0] fmt  [NUM_CH];
  logic [WORD_BITS-1:0] held [NUM_CH];

  assign samp[CH_LEFT]  = left_i;
  assign samp[CH_RIGHT] = right_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    if (SAMPLE_W >= WORD_BITS) begin : g_trunc
      assign fmt[ch] = samp[ch][SAMPLE_W-1 -: WORD_BITS];
    end else if (ALIGN == ALIGN_SIGN) begin : g_sext
      assign fmt[ch] = {{PAD_W{samp[ch][SAMPLE_W-1]}}, samp[ch]};
    end else begin : g_ljust
      assign fmt[ch] = {samp[ch], {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        held[ch] <= '0;
      end else if (load_i) begin
        held[ch] <= fmt[ch];
      end
    end
  end

  assign word_l_o = held[CH_LEFT];
  assign word_r_o = held[CH_RIGHT];

  // Held words only move on the frame-boundary capture.
  assert_hold_between_loads_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> ($stable(word_l_o) && $stable(word_r_o)));

endmodule

// File: rtl/i2s_serializer.sv
module i2s_serializer #(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32,
  parameter int BIT_W     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 fall_nxt_i,
  input  logic [BIT_W-1:0]     bit_nxt_i,
  input  logic                 bclk_i,
  input  logic                 ws_i,
  input  logic [WORD_BITS-1:0] word_l_i,
  input  logic [WORD_BITS-1:0] word_r_i,
  output logic                 sd_o
);

  logic                 right_slot;
  logic [BIT_W-1:0]     slot_pos;
  logic [WORD_BITS-1:0] cur_word;
  logic                 bit_val;
  logic                 sd_q;

  always_comb begin
    right_slot = (bit_nxt_i >= BIT_W'(SLOT_BITS));
    slot_pos   = right_slot ? (bit_nxt_i - BIT_W'(SLOT_BITS)) : bit_nxt_i;
    cur_word   = right_slot ? word_r_i : word_l_i;
    bit_val    = 1'b0;
    // Slot position n (1..WORD_BITS) carries word bit WORD_BITS-n; all else pads zero.
    for (int i = 0; i < WORD_BITS; i++) begin
      if (slot_pos == BIT_W'(WORD_BITS - i)) begin
        bit_val = cur_word[i];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sd_q <= 1'b0;
    end else if (fall_nxt_i) begin
      sd_q <= bit_val;
    end
  end

  assign sd_o = sd_q;

  // Serial data moves only on a falling bit clock.
  assert_sd_on_fall_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(sd_q) |-> $fell(bclk_i));

  // A word-select change starts a slot with its zero lead bit.
  assert_lead_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(ws_i) |-> !sd_q);

endmodule

// File: rtl/i2s_frame_tx.sv
module i2s_frame_tx
  import i2s_tx_pkg::*;
#(
  parameter int     SAMPLE_W  = 16,
  parameter int     WORD_BITS = 24,
  parameter int     SLOT_BITS = 32,
  parameter int     BCLK_DIV  = 4,
  parameter int     REQ_POS   = 4,
  parameter align_e ALIGN     = ALIGN_SIGN
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sample_req_o,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);

  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int PH_W       = (BCLK_DIV > 1) ? $clog2(BCLK_DIV) : 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  logic [BIT_W-1:0]     bit_nxt;
  logic                 fall_nxt;
  logic                 load;
  logic                 bclk;
  logic                 ws;
  logic [WORD_BITS-1:0] word_l;
  logic [WORD_BITS-1:0] word_r;

  i2s_timebase #(
    .BCLK_DIV  (BCLK_DIV),
    .SLOT_BITS (SLOT_BITS),
    .REQ_POS   (REQ_POS),
    .PH_W      (PH_W),
    .BIT_W     (BIT_W)
  ) u_timebase (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bit_nxt_o  (bit_nxt),
    .fall_nxt_o (fall_nxt),
    .load_o     (load),
    .bclk_o     (bclk),
    .ws_o       (ws),
    .req_o      (sample_req_o)
  );

  i2s_sample_latch #(
    .SAMPLE_W  (SAMPLE_W),
    .WORD_BITS (WORD_BITS),
    .ALIGN     (ALIGN)
  ) u_latch (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load),
    .left_i   (left_i),
    .right_i  (right_i),
    .word_l_o (word_l),
    .word_r_o (word_r)
  );

  i2s_serializer #(
    .WORD_BITS (WORD_BITS),
    .SLOT_BITS (SLOT_BITS),
    .BIT_W     (BIT_W)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .fall_nxt_i (fall_nxt),
    .bit_nxt_i  (bit_nxt),
    .bclk_i     (bclk),
    .ws_i       (ws),
    .word_l_i   (word_l),
    .word_r_i   (word_r),
    .sd_o       (sd_o)
  );

  // The DAC master clock is the system clock itself.
  assign mclk_o = clk_i;
  assign bclk_o = bclk;
  assign ws_o   = ws;

endmodule

// File: tb/i2s_frame_tx_tb.sv
module i2s_frame_tx_tb;
  import i2s_tx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 16;
  localparam int FRAME      = 256;
  localparam int FRAMES     = 14;
  localparam int REQ        = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] l_in = '0;
  logic [SW-1:0] r_in = '0;

  logic req_s, mclk_s, bclk_s, ws_s, sd_s;
  logic req_j, mclk_j, bclk_j, ws_j, sd_j;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_frame_tx #(.SAMPLE_W(SW), .REQ_POS(REQ), .ALIGN(ALIGN_SIGN)) u_dut (
    .clk_i(clk), .rst_i(rst), .left_i(l_in), .right_i(r_in),
    .sample_req_o(req_s), .mclk_o(mclk_s), .bclk_o(bclk_s), .ws_o(ws_s), .sd_o(sd_s));

  i2s_frame_tx #(.SAMPLE_W(SW), .REQ_POS(REQ), .ALIGN(ALIGN_LEFT)) u_dut_lj (
    .clk_i(clk), .rst_i(rst), .left_i(l_in), .right_i(r_in),
    .sample_req_o(req_j), .mclk_o(mclk_j), .bclk_o(bclk_j), .ws_o(ws_j), .sd_o(sd_j));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] fmt_sext(input logic [15:0] s);
    return {{8{s[15]}}, s};
  endfunction

  function automatic logic [23:0] fmt_ljust(input logic [15:0] s);
    return {s, 8'h00};
  endfunction

  // Expected serial bit at frame cycle c for the held pair (wl, wr).
  function automatic logic exp_sd(input logic [23:0] wl, input logic [23:0] wr, input int c);
    int b  = c / 4;
    int sb = b % 32;
    logic [23:0] w = (b >= 32) ? wr : wl;
    if (sb >= 1 && sb <= 24) return w[24 - sb];
    return 1'b0;
  endfunction

  function automatic logic [15:0] pat(input int idx, input bit rch);
    case (idx)
      0: return rch ? 16'h8000 : 16'h7FFF;
      1: return rch ? 16'h0001 : 16'hFFFF;
      2: return rch ? 16'h7FFF : 16'h8000;
      3: return rch ? 16'hFFFF : 16'h0000;
      4: return rch ? 16'h5555 : 16'hAAAA;
      5: return rch ? 16'hEDCB : 16'h1234;
      6: return rch ? 16'h7FFE : 16'h8001;
      default: return 16'(idx * 16'h1F35) ^ (rch ? 16'h3C3C : 16'hC0DE);
    endcase
  endfunction

  task automatic check_all_zero(input string tag);
    chk({tag, " bclk"}, 32'(bclk_s), 0);
    chk({tag, " ws"},   32'(ws_s),   0);
    chk({tag, " sd"},   32'(sd_s),   0);
    chk({tag, " req"},  32'(req_s),  0);
    chk({tag, " sd lj"}, 32'(sd_j),  0);
    chk({tag, " req lj"}, 32'(req_j), 0);
  endtask

  initial begin
    logic [23:0] hl_s, hr_s, hl_j, hr_j;
    logic [23:0] pl_s, pr_s, pl_j, pr_j;
    logic [15:0] lfsr;
    logic        prev_sd;
    hl_s = '0; hr_s = '0; hl_j = '0; hr_j = '0;
    pl_s = '0; pr_s = '0; pl_j = '0; pr_j = '0;
    lfsr = 16'hACE1;

    // R1: forwarded master clock follows the system clock.
    @(posedge clk); #1;
    chk("R1 mclk high", 32'(mclk_s), 1);
    @(negedge clk);
    chk("R1 mclk low", 32'(mclk_s), 0);
    chk("R1 mclk low lj", 32'(mclk_j), 0);

    // R10: outputs held at zero during reset.
    repeat (3) @(negedge clk);
    check_all_zero("R10 in reset");
    rst = 1'b0;
    check_all_zero("R10 release");
    prev_sd = sd_s;

    for (int k = 1; k <= FRAMES * FRAME; k++) begin
      int c;
      @(negedge clk);
      c = k % FRAME;
      if (c == 0) begin
        hl_s = pl_s; hr_s = pr_s; hl_j = pl_j; hr_j = pr_j;
      end
      chk("R2 bclk", 32'(bclk_s), 32'((c % 4) >= 2));
      chk("R3 ws",   32'(ws_s),   32'(c >= 128));
      chk("R9 req",  32'(req_s),  32'(c == REQ));
      chk("R4 R6 R7 R10 sd sext", 32'(sd_s), 32'(exp_sd(hl_s, hr_s, c)));
      chk("R4 R6 R8 R10 sd ljust", 32'(sd_j), 32'(exp_sd(hl_j, hr_j, c)));
      chk("R2 R3 lj timing", {30'd0, bclk_j, ws_j}, {30'd0, ((c % 4) >= 2), (c >= 128)});
      if (sd_s !== prev_sd) chk("R5 sd change phase", 32'(c % 4), 0);
      prev_sd = sd_s;

      if (c == FRAME - 1) begin
        l_in = pat(k / FRAME - 1, 1'b0);
        r_in = pat(k / FRAME - 1, 1'b1);
        pl_s = fmt_sext(l_in);  pr_s = fmt_sext(r_in);
        pl_j = fmt_ljust(l_in); pr_j = fmt_ljust(r_in);
      end else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        l_in = lfsr;
        r_in = lfsr ^ 16'h5A5A;
      end
    end

    // R10: a reset in mid-frame returns everything to zero.
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_all_zero("R10 mid-frame reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R2: got %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule